// File: doc/BRIEF.md
# Burst Timeslot Scheduler

This block paces the acquisition bursts of a key-sensing matrix. Each burst start falls into a fixed timeslot, so the scan runs in an orderly way and the response time is predictable. A single spacing value sets the interval from the start of one burst to the start of the next, and that value applies to every key. A 4-bit code selects the spacing. Codes 1 to 11 give fixed spacings from 500 µs up to 3 ms in steps of 250 µs. Code 0, which is the default, selects an automatic spacing.

In automatic mode the block takes the first measured conversion length presented after reset. It keeps the smallest fixed spacing that still covers that length plus a 100 µs margin, and holds that choice until the next reset. Time is counted in microsecond ticks supplied from outside.

A scan-start pulse launches one pass over the keys that are enabled. Each enabled key gets one burst-start strobe with its index. After the slot of the last key has closed, a scan-done pulse follows.

None of the outputs can be stalled. The block has no valid/ready handshake and does not accept back-pressure. A scan-start pulse that arrives while a scan is in progress is dropped. The downstream burst engine must accept every strobe in the cycle in which it is raised.

Top module: `burst_slot_sched`

## Requirements
- R1: While reset is held, and in the first cycle after reset, burst_start and scan_done are 0 and burst_key is 0.
- R2: For a fixed code c from 1 to 11, consecutive burst starts within a scan are exactly 500 + (c−1)×250 us_tick pulses apart, and this holds for every key.
- R3: Codes 12 to 15 behave as code 11, giving a spacing of 3000 ticks.
- R4: A scan_start accepted while idle produces a burst_start for the lowest enabled key in the following cycle. The remaining enabled keys follow in ascending index order. Disabled keys are skipped and use no slot.
- R5: scan_done pulses for one cycle, in the cycle after the tick that closes the last key's slot. If the mask has no bits set, scan_done pulses in the cycle after scan_start and no burst is issued.
- R6: The spacing code and the key mask are captured when the scan starts. Changing either during a scan has no effect until the next scan.
- R7: A scan_start that arrives while a scan is in progress is ignored.
- R8: With code 0, the spacing is the smallest fixed spacing that is at least the measured length plus 100 µs, and it saturates at 3000. The measurement is the one on the first conv_len_valid after reset. Later measurements are ignored until the next reset.
- R9: If code 0 is used before any measurement has arrived since reset, the spacing is 3000 ticks.
- R10: burst_start and scan_done are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spacing_code | input | 4 | Spacing selection: 0 is automatic, 1 to 11 are fixed spacings, 12 to 15 saturate to 11 |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| scan_start | input | 1 | Pulse that requests one pass over the enabled keys |
| key_en | input | NUM_KEYS | Key-enable mask; bit i enables key i |
| conv_len_us | input | 12 | Measured conversion length in microseconds |
| conv_len_valid | input | 1 | conv_len_us is valid in this cycle |
| burst_start | output | 1 | One-cycle strobe that marks the start of a burst |
| burst_key | output | KEY_W | Index of the key whose burst starts |
| scan_done | output | 1 | One-cycle pulse when the scan has finished |

## Verification
The bench targets several corner cases, each of which would expose a specific design error:
- Sparse masks with gaps at both ends. A design that gave disabled keys a slot would show doubled intervals, and one that ordered keys wrongly would produce key mismatches.
- The spacing code and the mask are rewritten in the middle of a scan, and a second scan_start is sent at the same point. A design that read them live would switch to the 3000-tick spacing or add keys. A design that restarted would reset the tick count.
- Out-of-range codes are used. A design that did not saturate them would produce spacings beyond 3 ms.
- The empty mask is tested, because a hung scan would never report done.
- For automatic mode, the bench sends a second, smaller measurement after the first and also uses the mode with no measurement at all. A fit that was not frozen would shrink to 500 ticks. A missing default would give a short or zero spacing.

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int US_W      = 12;
  localparam int CODE_W    = 4;
  localparam int CODE_MAX  = 11;
  localparam int BASE_US   = 500;
  localparam int STEP_US   = 250;
  localparam int MARGIN_US = 100;

  typedef enum logic {ST_IDLE, ST_SLOT} sched_st_t;

  // spacing in microseconds for a fixed code in 1..CODE_MAX
  function automatic logic [US_W-1:0] code_to_us(input logic [CODE_W-1:0] c);
    return US_W'(BASE_US + (int'(c) - 1) * STEP_US);
  endfunction

  // smallest fixed code whose spacing covers conv + margin, saturating
  function automatic logic [CODE_W-1:0] fit_code(input logic [US_W-1:0] conv);
    int need;
    int pick;
    need = int'(conv) + MARGIN_US;
    pick = CODE_MAX;
    for (int c = CODE_MAX; c >= 1; c--) begin
      if (BASE_US + (c - 1) * STEP_US >= need) pick = c;
    end
    return CODE_W'(pick);
  endfunction
endpackage

// File: rtl/bss_spacing_select.sv
module bss_spacing_select
  import bss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic [US_W-1:0]   conv_us,
  input  logic              conv_valid,
  input  logic              load,
  output logic [US_W-1:0]   slot_us
);
  logic              fit_done;
  logic [CODE_W-1:0] fit_sel;
  logic [CODE_W-1:0] eff_code;

  // one-shot best fit after reset; default is the longest spacing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fit_done <= 1'b0;
      fit_sel  <= CODE_W'(CODE_MAX);
    end else if (conv_valid && !fit_done) begin
      fit_done <= 1'b1;
      fit_sel  <= fit_code(conv_us);
    end
  end

  always_comb begin
    if (code_in == '0)                     eff_code = fit_sel;
    else if (code_in > CODE_W'(CODE_MAX))  eff_code = CODE_W'(CODE_MAX);
    else                                   eff_code = code_in;
  end

  // spacing is captured only when a scan is accepted
  always_ff @(posedge clk) begin
    if (!rst_n)    slot_us <= code_to_us(CODE_W'(CODE_MAX));
    else if (load) slot_us <= code_to_us(eff_code);
  end

  // R8
  fit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fit_done |=> (fit_done && $stable(fit_sel)));

  // R3
  spacing_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_us >= US_W'(BASE_US)) && (slot_us <= code_to_us(CODE_W'(CODE_MAX))));
endmodule

// File: rtl/bss_slot_timer.sv
module bss_slot_timer
  import bss_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  input  logic            tick,
  input  logic [US_W-1:0] limit,
  output logic            slot_end
);
  logic [US_W-1:0] cnt;

  assign slot_end = run && tick && (cnt == limit - US_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || !run) cnt <= '0;
    else if (tick)           cnt <= cnt + US_W'(1);
  end

  // R2
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < limit));
endmodule

// File: rtl/bss_key_picker.sv
module bss_key_picker #(
  parameter int N  = 8,
  parameter int KW = 3
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [KW-1:0] idx
);
  always_comb begin
    any = |pend;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = KW'(i);
    end
  end
endmodule

// File: rtl/burst_slot_sched.sv
module burst_slot_sched
  import bss_pkg::*;
#(
  parameter  int NUM_KEYS = 8,
  localparam int KEY_W    = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   spacing_code,
  input  logic                us_tick,
  input  logic                scan_start,
  input  logic [NUM_KEYS-1:0] key_en,
  input  logic [US_W-1:0]     conv_len_us,
  input  logic                conv_len_valid,
  output logic                burst_start,
  output logic [KEY_W-1:0]    burst_key,
  output logic                scan_done
);
  sched_st_t           state;
  logic [NUM_KEYS-1:0] pend;
  logic [NUM_KEYS-1:0] pick_src;
  logic                pick_any;
  logic [KEY_W-1:0]    pick_idx;
  logic                scan_accept;
  logic                slot_end;
  logic                issue;
  logic [US_W-1:0]     slot_us;

  assign scan_accept = (state == ST_IDLE) && scan_start;
  assign pick_src    = scan_accept ? key_en : pend;
  assign issue       = (scan_accept || slot_end) && pick_any;

  bss_spacing_select u_space (
    .clk(clk), .rst_n(rst_n), .code_in(spacing_code),
    .conv_us(conv_len_us), .conv_valid(conv_len_valid),
    .load(scan_accept), .slot_us(slot_us)
  );

  bss_slot_timer u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SLOT),
    .restart(issue), .tick(us_tick), .limit(slot_us), .slot_end(slot_end)
  );

  bss_key_picker #(.N(NUM_KEYS), .KW(KEY_W)) u_pick (
    .pend(pick_src), .any(pick_any), .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pend        <= '0;
      burst_start <= 1'b0;
      burst_key   <= '0;
      scan_done   <= 1'b0;
    end else begin
      burst_start <= 1'b0;
      scan_done   <= 1'b0;
      if (scan_accept || slot_end) begin
        if (pick_any) begin
          burst_start <= 1'b1;
          burst_key   <= pick_idx;
          pend        <= pick_src & ~(NUM_KEYS'(1) << pick_idx);
          state       <= ST_SLOT;
        end else begin
          scan_done <= 1'b1;
          pend      <= '0;
          state     <= ST_IDLE;
        end
      end
    end
  end

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst_start && scan_done));

  // R6
  pend_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLOT) |=> ((pend & ~$past(pend)) == '0));

  // R4
  issue_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> ($past(scan_accept) || $past(slot_end)));

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLOT && !slot_end) |=> (!burst_start && !scan_done));
endmodule

// File: tb/burst_slot_sched_test.sv
module burst_slot_sched_test;
  typedef struct {
    int    key;
    int    ticks;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] spacing_code = 4'd0;
  logic       us_tick = 1'b0;
  logic       scan_start = 1'b0;
  logic [7:0] key_en = 8'h00;
  logic [11:0] conv_len_us = 12'd0;
  logic       conv_len_valid = 1'b0;
  logic       burst_start;
  logic [2:0] burst_key;
  logic       scan_done;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   tcnt = 0;
  bit   mon_busy = 0;

  always #10 clk = ~clk;

  burst_slot_sched uut (
    .clk(clk), .rst_n(rst_n), .spacing_code(spacing_code), .us_tick(us_tick),
    .scan_start(scan_start), .key_en(key_en), .conv_len_us(conv_len_us),
    .conv_len_valid(conv_len_valid), .burst_start(burst_start),
    .burst_key(burst_key), .scan_done(scan_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // tick every second cycle, changed just after the edge
  initial forever begin
    step();
    us_tick = ~us_tick;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_busy = 0;
      tcnt     = 0;
    end else begin
      if (burst_start || scan_done) begin
        chk(!(burst_start && scan_done), "R10", "both strobes high", 1, 0);
        if (q.size() == 0) begin
          chk(0, "R4", "unexpected strobe, key", burst_start ? int'(burst_key) : -1, -2);
        end else begin
          exp_t e;
          int   ak;
          e  = q.pop_front();
          ak = burst_start ? int'(burst_key) : -1;
          chk(ak == e.key, e.req, "key (-1 = done)", ak, e.key);
          chk(tcnt == e.ticks, e.req, "ticks since previous event", tcnt, e.ticks);
        end
        if (scan_done) mon_busy = 0;
        tcnt = 0;
      end
      if (scan_start && !mon_busy) begin
        mon_busy = 1;
        tcnt     = 0;
      end else if (us_tick) begin
        tcnt++;
      end
    end
  end

  function automatic int fixed_us(input int c);
    return 500 + (c - 1) * 250;
  endfunction

  task automatic push_scan(input logic [7:0] mask, input int sp, input string req);
    exp_t e;
    bit   first = 1;
    for (int k = 0; k < 8; k++) begin
      if (mask[k]) begin
        e.key = k; e.ticks = first ? 0 : sp; e.req = req;
        q.push_back(e);
        first = 0;
      end
    end
    e.key = -1; e.ticks = first ? 0 : sp; e.req = req;
    q.push_back(e);
  endtask

  task automatic pulse_start();
    scan_start = 1'b1;
    step();
    scan_start = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) step();
    step();
  endtask

  task automatic run_scan(input int code, input logic [7:0] mask,
                          input int sp, input string req);
    spacing_code = 4'(code);
    key_en       = mask;
    push_scan(mask, sp, req);
    pulse_start();
    drain();
  endtask

  initial begin
    // R1 during reset
    repeat (3) step();
    chk(!burst_start && !scan_done && burst_key == 0, "R1", "outputs in reset",
        int'({burst_start, scan_done, burst_key}), 0);
    rst_n = 1'b1;
    step();
    chk(!burst_start && !scan_done && burst_key == 0, "R1", "outputs after reset",
        int'({burst_start, scan_done, burst_key}), 0);

    // R8: first measurement 820 -> needs 920 -> 1000; later 100 ignored
    conv_len_us = 12'd820; conv_len_valid = 1'b1; step(); conv_len_valid = 1'b0;
    step();
    conv_len_us = 12'd100; conv_len_valid = 1'b1; step(); conv_len_valid = 1'b0;

    // R2 R4 R5: sparse mask, fixed code 1
    run_scan(1, 8'b1010_0101, fixed_us(1), "R2/R4");
    // R2: single high key, code 2
    run_scan(2, 8'b1000_0000, fixed_us(2), "R2");
    // R3: code 13 saturates to 3000
    run_scan(13, 8'b0000_1000, 3000, "R3");
    // R8: automatic fit frozen at 1000
    run_scan(0, 8'b0000_0011, 1000, "R8");
    // R5: empty mask
    run_scan(4, 8'h00, 0, "R5");

    // R6 R7: change code/mask mid scan and retrigger
    spacing_code = 4'd1;
    key_en       = 8'b1000_0001;
    push_scan(8'b1000_0001, fixed_us(1), "R6/R7");
    pulse_start();
    repeat (300) step();
    spacing_code = 4'd11;
    key_en       = 8'hFF;
    pulse_start();
    drain();

    // R9: fresh reset, automatic mode with no measurement
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    run_scan(0, 8'b0000_0001, 3000, "R9");

    chk(q.size() == 0, "R5", "leftover expected events", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R5 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule